// File: doc/BRIEF.md
# Test Traffic Register and Pattern Engine

This block sits behind a simple word-addressed register port and does two jobs. First, it decodes each access into one of two windows. The low window is forwarded untouched to the register port of an external network offload engine. The second window holds a small local bank of control and status registers. Second, it drives test traffic through a pair of 64-bit FIFO ports. A generator fills the engine's transmit FIFO with an incrementing pattern until a programmed number of words has been written. A checker drains the receive FIFO and, when asked to, compares every word against the same pattern.

Firmware programs the transmit length and then writes the command register. Writing zero to the start bit launches the generator. The same write clears both word counters and sets the verify mode. Firmware then polls the counters, the busy bit and the sticky error bit.

Each pattern word `n` carries the 32-bit value `2n` in its low half and `2n+1` in its high half, with 32-bit wrap. Back-pressure on the transmit side is the FIFO's full flag: the generator writes only in cycles where full is low. The receive side has no back-pressure: the checker pops a word in every cycle where the FIFO is not empty, and it takes the data one cycle after the pop.

Top module: `tgen_top`

## Requirements
- R1: Word addresses 0x000–0x03F are the engine window. In this window a write raises `eng_wr_en` with `eng_addr` equal to the address's low 6 bits and `eng_wr_data` equal to the write data, and a read returns `eng_rd_data`. Word addresses 0x400–0x43F are the local window, with local index equal to the address's low 6 bits. Any other address is outside both windows: a write there has no effect and a read there returns 0.
- R2: `reg_rd_valid` is high exactly in the cycle after a cycle with `reg_rd_req` high. `reg_rd_data` then holds the value selected by the address that was presented with the request.
- R3: `reg_wr_be` is ignored. Every local write updates all 32 bits, including a write made with `reg_wr_be` = 0.
- R4: Local index 0 (transmit length) works as follows. A write stores the total transmit length in 64-bit words. A read returns the number of words transmitted so far.
- R5: A write to local index 1 (command) does three things. It clears the transmit and receive word counters. If write bit 0 is 0, it starts transmission, provided the stored length is non-zero. It sets verify mode to write bit 1. A read of index 1 returns bit 0 = transmit busy, bit 1 = verify error and bit 2 = `conn_on`; all other bits read 0.
- R6: `tx_wr_en` is high only while transmission is busy and `tx_full` is low. Write `k` after a start carries pattern word `k`. Busy falls after the word that makes the count equal to the stored length.
- R7: `rx_rd_en` equals the inverse of `rx_empty`. The word arrives on `rx_data` one cycle after a pop, and each popped word advances the receive count. Local index 4 reads back the receive count.
- R8: The verify error bit is set when verify mode is on and the received word `k` differs from pattern word `k`. It is never set while verify mode is off. Once set, it stays set until the next command write or a logic reset.
- R9: Writing local index 2 with bit 0 = 1 issues a logic reset. The logic reset clears both counters, the busy bit and the error bit, so the pattern restarts from word 0. Bit 0 reads back as 0.
- R10: Local index 2 bit 8 reads a latched flag that is set whenever `timer_irq` is high. Writing index 2 with bit 8 = 1 clears that flag. Index 2 bit 16 reads `link_up`.
- R11: Local index 3 reads `rx_last_cnt` in bits [2:0], `rx_ff_cnt` in bits [15:3] and `tx_full` in bit 24; all other bits read 0.
- R12: Local indices 5 to 63 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 14 | Word address of the access |
| reg_wr_en | input | 1 | Write strobe |
| reg_wr_data | input | 32 | Write data |
| reg_wr_be | input | 4 | Byte enables (ignored) |
| reg_rd_req | input | 1 | Read request |
| reg_rd_data | output | 32 | Read data, valid with reg_rd_valid |
| reg_rd_valid | output | 1 | Read data valid, one cycle after request |
| eng_addr | output | 6 | Engine register index |
| eng_wr_en | output | 1 | Engine register write strobe |
| eng_wr_data | output | 32 | Engine register write data |
| eng_rd_data | input | 32 | Engine register read data for eng_addr |
| conn_on | input | 1 | Engine connection-on status |
| timer_irq | input | 1 | Engine timer interrupt |
| link_up | input | 1 | Ethernet link-up status |
| rx_last_cnt | input | 3 | Byte count of the last receive word |
| rx_ff_cnt | input | 13 | Receive FIFO read count |
| tx_wr_en | output | 1 | Transmit FIFO write |
| tx_data | output | 64 | Transmit FIFO write data |
| tx_full | input | 1 | Transmit FIFO full |
| rx_rd_en | output | 1 | Receive FIFO pop |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_data | input | 64 | Receive FIFO data, valid one cycle after pop |

## Verification
The assertions check the cycle-level rules in every cycle:
- the one-cycle read return;
- the forwarded engine write occurring only under a port write;
- no transmit write while full or idle, and busy falling at the programmed length;
- the receive pop tracking empty;
- the sticky error holding;
- the clearing effects of command writes and logic resets.

Only the bench scenarios can show the rest:
- the exact pattern values on both FIFO ports;
- counts and busy seen through the register map under stalls;
- the field layout of the status words;
- window decoding at the edges;
- that byte enables, verify-off mismatches and write-only bits have no visible effect.

// File: rtl/tgen_pkg.sv
`timescale 1ns/1ps
package tgen_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANE_W = 2 * WORD_W;
  localparam int unsigned LAST_W = 3;
  localparam int unsigned FCNT_W = 13;

  // local register indices inside the local window
  localparam int unsigned IDX_TXLEN = 0;
  localparam int unsigned IDX_CMD   = 1;
  localparam int unsigned IDX_CTRL  = 2;
  localparam int unsigned IDX_FIFO  = 3;
  localparam int unsigned IDX_RXLEN = 4;

  // control register bit positions
  localparam int unsigned CMD_START_N = 0;
  localparam int unsigned CMD_VERIFY  = 1;
  localparam int unsigned CTRL_SOFT   = 0;
  localparam int unsigned CTRL_IRQ    = 8;
  localparam int unsigned CTRL_LINK   = 16;

  typedef enum logic [1:0] {
    WIN_NONE   = 2'd0,
    WIN_ENGINE = 2'd1,
    WIN_LOCAL  = 2'd2
  } win_e;

  // pattern word n: low half 2n, high half 2n+1
  function automatic logic [LANE_W-1:0] pattern_word(input logic [WORD_W-1:0] n);
    logic [WORD_W-1:0] even;
    even = n << 1;
    return {even | WORD_W'(1), even};
  endfunction
endpackage

// File: rtl/tgen_decode.sv
`timescale 1ns/1ps
module tgen_decode
  import tgen_pkg::*;
#(
  parameter int unsigned ADDR_W     = 14,
  parameter int unsigned IDX_W      = 6,
  parameter int unsigned LOCAL_BASE = 'h400
) (
  input  logic [ADDR_W-1:0] addr,
  output win_e              win,
  output logic [IDX_W-1:0]  idx
);
  localparam int unsigned PAGE_W = ADDR_W - IDX_W;
  localparam logic [PAGE_W-1:0] ENGINE_PAGE = '0;
  localparam logic [PAGE_W-1:0] LOCAL_PAGE  = PAGE_W'(LOCAL_BASE >> IDX_W);

  logic [PAGE_W-1:0] page;

  assign page = addr[ADDR_W-1:IDX_W];
  assign idx  = addr[IDX_W-1:0];

  always_comb begin
    if (page == ENGINE_PAGE)
      win = WIN_ENGINE;
    else if (page == LOCAL_PAGE)
      win = WIN_LOCAL;
    else
      win = WIN_NONE;
  end
endmodule

// File: rtl/tgen_regfile.sv
`timescale 1ns/1ps
module tgen_regfile
  import tgen_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  win_e              win,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_req,
  input  logic [WORD_W-1:0] eng_rd_data,
  input  logic [WORD_W-1:0] tx_cnt,
  input  logic [WORD_W-1:0] rx_cnt,
  input  logic              tx_busy,
  input  logic              vfy_err,
  input  logic              conn_on,
  input  logic              timer_irq,
  input  logic              link_up,
  input  logic [LAST_W-1:0] rx_last_cnt,
  input  logic [FCNT_W-1:0] rx_ff_cnt,
  input  logic              tx_full,
  output logic [WORD_W-1:0] set_len,
  output logic              cmd_wr,
  output logic              start_req,
  output logic              verify_en,
  output logic              soft_rst,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam logic [IDX_W-1:0] I_TXLEN = IDX_W'(IDX_TXLEN);
  localparam logic [IDX_W-1:0] I_CMD   = IDX_W'(IDX_CMD);
  localparam logic [IDX_W-1:0] I_CTRL  = IDX_W'(IDX_CTRL);
  localparam logic [IDX_W-1:0] I_FIFO  = IDX_W'(IDX_FIFO);
  localparam logic [IDX_W-1:0] I_RXLEN = IDX_W'(IDX_RXLEN);
  localparam int unsigned FIFO_PAD = 24 - LAST_W - FCNT_W;

  logic local_wr;
  logic irq_clr;
  logic irq_lat;
  logic [WORD_W-1:0] rd_mux;
  logic [WORD_W-1:0] cmd_view;
  logic [WORD_W-1:0] ctrl_view;
  logic [WORD_W-1:0] fifo_view;

  assign local_wr  = wr_en && (win == WIN_LOCAL);
  assign cmd_wr    = local_wr && (idx == I_CMD);
  assign start_req = cmd_wr && !wr_data[CMD_START_N];
  assign soft_rst  = local_wr && (idx == I_CTRL) && wr_data[CTRL_SOFT];
  assign irq_clr   = local_wr && (idx == I_CTRL) && wr_data[CTRL_IRQ];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      set_len   <= '0;
      verify_en <= 1'b0;
    end else begin
      if (local_wr && (idx == I_TXLEN))
        set_len <= wr_data;
      if (cmd_wr)
        verify_en <= wr_data[CMD_VERIFY];
    end
  end

  // timer flag: a live interrupt wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)
      irq_lat <= 1'b0;
    else
      irq_lat <= (irq_lat && !irq_clr) || timer_irq;
  end

  always_comb begin
    cmd_view = '0;
    cmd_view[0] = tx_busy;
    cmd_view[1] = vfy_err;
    cmd_view[2] = conn_on;

    ctrl_view = '0;
    ctrl_view[CTRL_IRQ]  = irq_lat;
    ctrl_view[CTRL_LINK] = link_up;

    fifo_view = {7'd0, tx_full, FIFO_PAD'(0), rx_ff_cnt, rx_last_cnt};
  end

  always_comb begin
    rd_mux = '0;
    case (win)
      WIN_ENGINE: rd_mux = eng_rd_data;
      WIN_LOCAL: begin
        case (idx)
          I_TXLEN: rd_mux = tx_cnt;
          I_CMD:   rd_mux = cmd_view;
          I_CTRL:  rd_mux = ctrl_view;
          I_FIFO:  rd_mux = fifo_view;
          I_RXLEN: rd_mux = rx_cnt;
          default: rd_mux = '0;
        endcase
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req)
        rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/tgen_gen.sv
`timescale 1ns/1ps
module tgen_gen
  import tgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              cmd_wr,
  input  logic              start_req,
  input  logic [WORD_W-1:0] set_len,
  input  logic              tx_full,
  output logic              tx_wr_en,
  output logic [LANE_W-1:0] tx_data,
  output logic [WORD_W-1:0] tx_cnt,
  output logic              tx_busy
);
  logic [WORD_W-1:0] cnt_next;

  assign tx_wr_en = tx_busy && !tx_full;
  assign tx_data  = pattern_word(tx_cnt);
  assign cnt_next = tx_cnt + WORD_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      tx_cnt  <= '0;
      tx_busy <= 1'b0;
    end else if (cmd_wr) begin
      tx_cnt  <= '0;
      tx_busy <= start_req && (set_len != '0);
    end else if (tx_wr_en) begin
      tx_cnt <= cnt_next;
      if (cnt_next == set_len)
        tx_busy <= 1'b0;
    end
  end
endmodule

// File: rtl/tgen_vfy.sv
`timescale 1ns/1ps
module tgen_vfy
  import tgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              cmd_wr,
  input  logic              verify_en,
  input  logic              rx_empty,
  input  logic [LANE_W-1:0] rx_data,
  output logic              rx_rd_en,
  output logic [WORD_W-1:0] rx_cnt,
  output logic              vfy_err
);
  logic pop_q;
  logic mismatch;

  assign rx_rd_en = !rx_empty;
  assign mismatch = pop_q && verify_en && (rx_data != pattern_word(rx_cnt));

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst)
      pop_q <= 1'b0;
    else
      pop_q <= rx_rd_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst || cmd_wr) begin
      rx_cnt  <= '0;
      vfy_err <= 1'b0;
    end else begin
      if (pop_q)
        rx_cnt <= rx_cnt + WORD_W'(1);
      if (mismatch)
        vfy_err <= 1'b1;
    end
  end
endmodule

// File: rtl/tgen_top.sv
`timescale 1ns/1ps
module tgen_top
  import tgen_pkg::*;
#(
  parameter int unsigned ADDR_W     = 14,
  parameter int unsigned IDX_W      = 6,
  parameter int unsigned LOCAL_BASE = 'h400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [31:0]       reg_wr_data,
  input  logic [3:0]        reg_wr_be,
  input  logic              reg_rd_req,
  output logic [31:0]       reg_rd_data,
  output logic              reg_rd_valid,
  output logic [IDX_W-1:0]  eng_addr,
  output logic              eng_wr_en,
  output logic [31:0]       eng_wr_data,
  input  logic [31:0]       eng_rd_data,
  input  logic              conn_on,
  input  logic              timer_irq,
  input  logic              link_up,
  input  logic [2:0]        rx_last_cnt,
  input  logic [12:0]       rx_ff_cnt,
  output logic              tx_wr_en,
  output logic [63:0]       tx_data,
  input  logic              tx_full,
  output logic              rx_rd_en,
  input  logic              rx_empty,
  input  logic [63:0]       rx_data
);
  win_e              win;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] set_len;
  logic [WORD_W-1:0] tx_cnt;
  logic [WORD_W-1:0] rx_cnt;
  logic              tx_busy;
  logic              vfy_err;
  logic              cmd_wr;
  logic              start_req;
  logic              verify_en;
  logic              soft_rst;
  logic              be_unused;

  assign be_unused   = ^reg_wr_be;
  assign eng_addr    = idx;
  assign eng_wr_en   = reg_wr_en && (win == WIN_ENGINE);
  assign eng_wr_data = reg_wr_data;

  tgen_decode #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .LOCAL_BASE(LOCAL_BASE)
  ) u_decode (
    .addr(reg_addr), .win(win), .idx(idx)
  );

  tgen_regfile #(.IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .win(win), .idx(idx),
    .wr_en(reg_wr_en), .wr_data(reg_wr_data), .rd_req(reg_rd_req),
    .eng_rd_data(eng_rd_data), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .tx_busy(tx_busy), .vfy_err(vfy_err), .conn_on(conn_on),
    .timer_irq(timer_irq), .link_up(link_up), .rx_last_cnt(rx_last_cnt),
    .rx_ff_cnt(rx_ff_cnt), .tx_full(tx_full), .set_len(set_len),
    .cmd_wr(cmd_wr), .start_req(start_req), .verify_en(verify_en),
    .soft_rst(soft_rst), .rd_data(reg_rd_data), .rd_valid(reg_rd_valid)
  );

  tgen_gen u_gen (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cmd_wr(cmd_wr),
    .start_req(start_req), .set_len(set_len), .tx_full(tx_full),
    .tx_wr_en(tx_wr_en), .tx_data(tx_data), .tx_cnt(tx_cnt), .tx_busy(tx_busy)
  );

  tgen_vfy u_vfy (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cmd_wr(cmd_wr),
    .verify_en(verify_en), .rx_empty(rx_empty), .rx_data(rx_data),
    .rx_rd_en(rx_rd_en), .rx_cnt(rx_cnt), .vfy_err(vfy_err)
  );
endmodule

// File: rtl/tgen_top_sva.sv
`timescale 1ns/1ps
module tgen_top_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_rd_req,
  input logic        reg_rd_valid,
  input logic        reg_wr_en,
  input logic        eng_wr_en,
  input logic        tx_full,
  input logic        tx_wr_en,
  input logic        rx_empty,
  input logic        rx_rd_en,
  input logic        tx_busy,
  input logic [31:0] tx_cnt,
  input logic [31:0] set_len,
  input logic        vfy_err,
  input logic        cmd_wr,
  input logic        soft_rst
);
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_req |=> reg_rd_valid); // R2
  AST_RD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_req |=> !reg_rd_valid); // R2
  AST_ENG_WR_FROM_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    eng_wr_en |-> reg_wr_en); // R1
  AST_TX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> !tx_wr_en); // R6
  AST_TX_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> !tx_wr_en); // R6
  AST_TX_STOPS_AT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_en && (32'(tx_cnt + 32'd1) == set_len) && !cmd_wr && !soft_rst) |=> !tx_busy); // R6
  AST_RX_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd_en != rx_empty); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (vfy_err && !cmd_wr && !soft_rst) |=> vfy_err); // R8
  AST_CMD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (!vfy_err && tx_cnt == 32'd0)); // R5
  AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!tx_busy && !vfy_err && tx_cnt == 32'd0)); // R9
endmodule

bind tgen_top tgen_top_sva u_sva (.*);

// File: tb/tgen_top_test.sv
`timescale 1ns/1ps
module tgen_top_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [13:0] reg_addr = '0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [3:0]  reg_wr_be = '0;
  logic        reg_rd_req = 1'b0;
  logic [31:0] reg_rd_data;
  logic        reg_rd_valid;
  logic [5:0]  eng_addr;
  logic        eng_wr_en;
  logic [31:0] eng_wr_data;
  logic [31:0] eng_rd_data;
  logic        conn_on = 1'b0;
  logic        timer_irq = 1'b0;
  logic        link_up = 1'b0;
  logic [2:0]  rx_last_cnt = '0;
  logic [12:0] rx_ff_cnt = '0;
  logic        tx_wr_en;
  logic [63:0] tx_data;
  logic        tx_full = 1'b0;
  logic        rx_rd_en;
  logic        rx_empty;
  logic [63:0] rx_data = '0;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  tgen_top uut (.*);

  function automatic logic [63:0] expw(input int unsigned n);
    logic [31:0] a;
    a = 32'(2 * n);
    return {a + 32'd1, a};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // engine register port model
  logic [5:0]  eng_last_a = '0;
  logic [31:0] eng_last_d = '0;
  int          eng_wr_cnt = 0;
  assign eng_rd_data = 32'hE000_0000 | {26'd0, eng_addr};
  always @(posedge clk) if (eng_wr_en) begin
    eng_last_a <= eng_addr;
    eng_last_d <= eng_wr_data;
    eng_wr_cnt <= eng_wr_cnt + 1;
  end

  // receive FIFO model
  logic [63:0] rx_mem [0:63];
  int rx_wp = 0;
  int rx_rp = 0;
  assign rx_empty = (rx_wp == rx_rp);
  always @(posedge clk) if (rx_rd_en) begin
    rx_data <= rx_mem[rx_rp[5:0]];
    rx_rp   <= rx_rp + 1;
  end
  task automatic push(input logic [63:0] w);
    rx_mem[rx_wp[5:0]] = w;
    rx_wp++;
  endtask

  // transmit FIFO monitor
  int tx_seen = 0;
  int tx_base = 0;
  always @(negedge clk) begin
    #1;
    if (tx_wr_en) begin
      chk("R6 tx data pattern", tx_data, expw(tx_seen - tx_base));
      if (tx_full) chk("R6 write while full", 1, 0);
      tx_seen++;
    end
  end

  task automatic wr(input logic [13:0] a, input logic [31:0] d, input logic [3:0] be);
    reg_addr = a; reg_wr_data = d; reg_wr_be = be; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [13:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd_req = 1'b1;
    @(negedge clk);
    reg_rd_req = 1'b0;
    chk("R2 read valid one cycle after request", reg_rd_valid, 1);
    d = reg_rd_data;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  // status vectors: [31:0] inputs {link[17], full[16], ffcnt[15:3], last[2:0]},
  // [63:32] expected status word at local index 3
  localparam logic [63:0] VEC [4] = '{
    {32'h0100_D5E5, 32'h0003_D5E5},
    {32'h0000_FFF8, 32'h0000_FFF8},
    {32'h0100_0007, 32'h0001_0007},
    {32'h0000_000A, 32'h0002_000A}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int base_cnt;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(1);

    // reset state
    chk("R2 no valid after reset", reg_rd_valid, 0);
    chk("R6 no tx write after reset", tx_wr_en, 0);
    chk("R7 no pop while empty", rx_rd_en, 0);
    rd(14'h401, d); chk("R5 command reads idle", d, 0);
    rd(14'h400, d); chk("R4 tx count zero", d, 0);
    rd(14'h404, d); chk("R7 rx count zero", d, 0);

    // status vector table
    foreach (VEC[i]) begin
      rx_last_cnt = VEC[i][2:0];
      rx_ff_cnt   = VEC[i][15:3];
      tx_full     = VEC[i][16];
      link_up     = VEC[i][17];
      rd(14'h403, d); chk("R11 fifo status fields", d, VEC[i][63:32]);
      rd(14'h402, d); chk("R10 link bit16", d, {15'd0, VEC[i][17], 16'd0});
    end
    tx_full = 1'b0; link_up = 1'b0;

    // window decoding
    wr(14'h005, 32'hCAFE_0005, 4'h0);
    wait_cyc(1);
    chk("R1 engine write count", eng_wr_cnt, 1);
    chk("R1 engine write addr", eng_last_a, 6'h05);
    chk("R1 engine write data", eng_last_d, 32'hCAFE_0005);
    rd(14'h03F, d); chk("R1 engine read", d, 32'hE000_003F);
    rd(14'h040, d); chk("R1 gap read zero", d, 0);
    rd(14'h2400, d); chk("R1 far read zero", d, 0);
    wr(14'h040, 32'hFFFF_FFFF, 4'hF);
    wr(14'h2401, 32'h0, 4'hF);
    wait_cyc(3);
    chk("R1 outside write not forwarded", eng_wr_cnt, 1);
    chk("R1 outside write starts nothing", tx_seen, 0);
    rd(14'h405, d); chk("R12 unmapped local zero", d, 0);
    rd(14'h43F, d); chk("R12 top local index zero", d, 0);
    reg_rd_req = 1'b0; wait_cyc(1);
    chk("R2 valid drops without request", reg_rd_valid, 0);

    // transmit with byte enables zero
    conn_on = 1'b1;
    wr(14'h400, 32'd5, 4'h0);
    tx_base = tx_seen;
    wr(14'h401, 32'h0, 4'h0);
    wait_cyc(12);
    chk("R3 length written with be=0", tx_seen - tx_base, 5);
    rd(14'h400, d); chk("R4 tx count equals length", d, 5);
    rd(14'h401, d); chk("R5 idle with conn_on", d, 32'h4);
    conn_on = 1'b0;

    // back-pressure
    wr(14'h400, 32'd8, 4'hF);
    tx_full = 1'b1;
    tx_base = tx_seen;
    wr(14'h401, 32'h0, 4'hF);
    wait_cyc(5);
    chk("R6 stalled while full", tx_seen - tx_base, 0);
    rd(14'h401, d); chk("R5 busy while stalled", d, 32'h1);
    tx_full = 1'b0;
    wait_cyc(3);
    tx_full = 1'b1;
    wait_cyc(2);
    chk("R6 writes during open window", tx_seen - tx_base, 3);
    rd(14'h400, d); chk("R4 partial tx count", d, 3);
    tx_full = 1'b0;
    wait_cyc(12);
    chk("R6 total after release", tx_seen - tx_base, 8);
    rd(14'h401, d); chk("R6 busy falls at length", d, 0);

    // receive with verify
    wr(14'h401, 32'h3, 4'hF);
    for (int k = 0; k < 6; k++) push(expw(k));
    wait_cyc(12);
    rd(14'h404, d); chk("R7 rx count", d, 6);
    rd(14'h401, d); chk("R8 no error on clean data", d, 0);
    push(expw(6)); push(expw(7)); push(expw(8) ^ 64'h1); push(expw(9));
    wait_cyc(10);
    rd(14'h404, d); chk("R7 rx count after more", d, 10);
    rd(14'h401, d); chk("R8 error on mismatch", d, 32'h2);
    push(expw(10));
    wait_cyc(6);
    rd(14'h401, d); chk("R8 error sticky", d, 32'h2);
    wr(14'h401, 32'h3, 4'hF);
    rd(14'h401, d); chk("R5 command clears error", d, 0);
    rd(14'h404, d); chk("R5 command clears rx count", d, 0);
    wr(14'h401, 32'h1, 4'hF);
    push(64'h1234); push(64'h5678); push(64'h9ABC);
    wait_cyc(8);
    rd(14'h401, d); chk("R8 verify off ignores mismatch", d, 0);
    rd(14'h404, d); chk("R7 rx count with verify off", d, 3);

    // logic reset
    tx_full = 1'b1;
    wr(14'h400, 32'd4, 4'hF);
    base_cnt = tx_seen;
    wr(14'h401, 32'h2, 4'hF);
    push(expw(0)); push(expw(1)); push(expw(5));
    wait_cyc(8);
    rd(14'h401, d); chk("R8 busy and error before reset", d, 32'h3);
    wr(14'h402, 32'h1, 4'hF);
    rd(14'h401, d); chk("R9 reset clears busy and error", d, 0);
    rd(14'h404, d); chk("R9 reset clears rx count", d, 0);
    rd(14'h402, d); chk("R9 reset bit reads zero", d, 0);
    tx_full = 1'b0;
    wait_cyc(5);
    chk("R9 no tx after reset", tx_seen - base_cnt, 0);
    push(expw(0)); push(expw(1));
    wait_cyc(6);
    rd(14'h401, d); chk("R9 pattern restarts from zero", d, 0);
    rd(14'h404, d); chk("R9 rx count after restart", d, 2);

    // timer flag
    timer_irq = 1'b1; wait_cyc(1); timer_irq = 1'b0;
    rd(14'h402, d); chk("R10 timer flag latched", d, 32'h100);
    wait_cyc(3);
    rd(14'h402, d); chk("R10 timer flag holds", d, 32'h100);
    wr(14'h402, 32'h100, 4'hF);
    rd(14'h402, d); chk("R10 timer flag cleared", d, 0);
    link_up = 1'b1;
    rd(14'h402, d); chk("R10 link up", d, 32'h1_0000);

    done = 1;
    summary();
    $finish;
  end
endmodule